// File: doc/BRIEF.md
# Addressed Bus Slave Responder

This block is the decision logic of one slave station on a shared half-duplex serial bus that a single master polls. A receiver ahead of it hands over each complete byte with a one-cycle strobe. The block compares the low three bits of that byte with the station number fixed for this instance. If they differ, the block does nothing. If they agree, bit 7 sets a local output pin. A reply is then scheduled after a fixed turnaround gap. The reply carries the station number and the state of a local feedback pin.

The station speaks only when it is polled at its own number. A change on the feedback pin never starts a transmission; the master sees that change only on its next poll. The turnaround gap is set in whole bit times, so the master has time to release the line before the slave drives it.

Top module: `slv_bus_responder`

## Requirements
- R1: While rst_ni is low, out_o, tx_send_o and tx_data_o are all 0.
- R2: A byte accepted on rx_valid_i matches when rx_data_i[2:0] equals NODE_ADDR. Bits 6:3 of the byte play no part in the match or in the action taken.
- R3: On a matching byte, out_o takes the value of rx_data_i[7] at the clock edge that accepts the byte.
- R4: On a non-matching byte, out_o keeps its value and no tx_send_o pulse follows.
- R5: The reply byte has NODE_ADDR in bits 2:0, the feedback state in bit 7 and zeros in bits 6:3. tx_data_o reads 0 whenever tx_send_o is low.
- R6: tx_send_o is a single-cycle pulse. It is seen exactly GAP_BITS*BIT_CYCLES clock cycles after the edge that accepted the matching byte.
- R7: fb_i passes through a two-flop synchroniser. The reply reports the synchronised feedback value at the send edge, so a level held stable for at least three cycles before the send is reported.
- R8: A change on fb_i never causes a tx_send_o pulse on its own.
- R9: Any byte accepted while a reply is pending cancels that reply. If the new byte matches, a new gap starts from its acceptance.
- R10: Between accepted matching bytes, out_o holds its last commanded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is present |
| rx_data_i | input | 8 | Received byte: station number in bits 2:0, command in bit 7 |
| fb_i | input | 1 | Asynchronous local feedback input |
| tx_send_o | output | 1 | One-cycle strobe telling the transmitter to send tx_data_o |
| tx_data_o | output | 8 | Reply byte |
| out_o | output | 1 | Commanded local output |

## Verification
A wrong address compare shows up straight away. Either out_o changes on a byte meant for another station, or a reply pulse appears that the scoreboard does not expect, within GAP_BITS*BIT_CYCLES cycles of that byte. A turnaround counter that is off by any amount moves the reply stamp away from the expected cycle on the very first poll. A pending flag that is not cleared on a new byte produces a stray reply one gap after a cancelled poll. A bad synchroniser tap or a bad bit position gives a wrong reply byte on the first poll in which the feedback level differs from the command level.

// File: rtl/slv_resp_pkg.sv
package slv_resp_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int CMD_POS = 7;
  localparam int FB_POS  = 7;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  function automatic byte_t make_reply(addr_t a, logic fb);
    byte_t r;
    r = '0;
    r[ADDR_W-1:0] = a;
    r[FB_POS] = fb;
    return r;
  endfunction
endpackage

// File: rtl/slv_sync.sv
module slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q[0] <= 1'b0;
          else         q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q[i] <= 1'b0;
          else         q[i] <= q[i-1];
      end
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/slv_decode.sv
module slv_decode
  import slv_resp_pkg::*;
#(
  parameter addr_t NODE_ADDR = 3'd5
) (
  input  byte_t rx_data_i,
  output logic  hit_o,
  output logic  cmd_o
);
  // only the address field takes part in the compare
  assign hit_o = (rx_data_i[ADDR_W-1:0] == NODE_ADDR);
  assign cmd_o = rx_data_i[CMD_POS];
endmodule

// File: rtl/slv_turn_timer.sv
module slv_turn_timer #(
  parameter int DELAY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic hit_i,
  output logic fire_o
);
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

  logic          pending_q;
  logic [CW-1:0] cnt_q;

  // a new byte always wins over a reply that is about to go out
  assign fire_o = pending_q && (cnt_q == '0) && !accept_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else if (accept_i) begin
      pending_q <= hit_i;
      cnt_q     <= LOAD;
    end else if (pending_q) begin
      if (cnt_q == '0) pending_q <= 1'b0;
      else             cnt_q     <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/slv_reply_reg.sv
module slv_reply_reg
  import slv_resp_pkg::*;
#(
  parameter addr_t NODE_ADDR = 3'd5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fire_i,
  input  logic  fb_i,
  output logic  send_o,
  output byte_t data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      send_o <= 1'b0;
      data_o <= '0;
    end else begin
      send_o <= fire_i;
      data_o <= fire_i ? make_reply(NODE_ADDR, fb_i) : '0;
    end
  end
endmodule

// File: rtl/slv_bus_responder.sv
module slv_bus_responder
  import slv_resp_pkg::*;
#(
  parameter addr_t NODE_ADDR  = 3'd5,
  parameter int    BIT_CYCLES = 16,
  parameter int    GAP_BITS   = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       fb_i,
  output logic       tx_send_o,
  output logic [7:0] tx_data_o,
  output logic       out_o
);
  localparam int DELAY = BIT_CYCLES * GAP_BITS;

  logic hit, cmd, fire, fb_s;

  slv_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fb_i), .q_o(fb_s)
  );

  slv_decode #(.NODE_ADDR(NODE_ADDR)) u_dec (
    .rx_data_i(rx_data_i), .hit_o(hit), .cmd_o(cmd)
  );

  slv_turn_timer #(.DELAY(DELAY)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(rx_valid_i),
    .hit_i(hit), .fire_o(fire)
  );

  slv_reply_reg #(.NODE_ADDR(NODE_ADDR)) u_rep (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .fb_i(fb_s),
    .send_o(tx_send_o), .data_o(tx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               out_o <= 1'b0;
    else if (rx_valid_i && hit) out_o <= cmd;
  end
endmodule

// File: rtl/slv_bus_responder_chk.sv
module slv_bus_responder_chk #(
  parameter logic [2:0] NODE_ADDR  = 3'd5,
  parameter int         BIT_CYCLES = 16,
  parameter int         GAP_BITS   = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       fb_i,
  input logic       tx_send_o,
  input logic [7:0] tx_data_o,
  input logic       out_o
);
  localparam int DELAY = BIT_CYCLES * GAP_BITS;

  logic        armed;
  int unsigned gap;
  int unsigned since_rst;
  logic        hit;

  assign hit = rx_valid_i && (rx_data_i[2:0] == NODE_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed <= 1'b0;
      gap   <= 0;
      since_rst <= 0;
    end else begin
      if (since_rst < 100) since_rst <= since_rst + 1;
      if (rx_valid_i) begin
        armed <= hit;
        gap   <= 0;
      end else if (tx_send_o) begin
        armed <= 1'b0;
      end else if (armed && gap < 32'hFFFF_FFFF) begin
        gap <= gap + 1;
      end
    end
  end

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_R1: assert (!out_o && !tx_send_o && tx_data_o == 8'h00);

  assert_hit_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> out_o == $past(rx_data_i[7]));

  assert_miss_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !hit) |=> $stable(out_o));

  assert_reply_fmt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_send_o |-> (tx_data_o[2:0] == NODE_ADDR && tx_data_o[6:3] == 4'h0));

  assert_idle_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_send_o |-> tx_data_o == 8'h00);

  assert_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_send_o |=> !tx_send_o);

  // R9: a cancelled poll disarms, so any send must trace to the latest byte
  assert_send_timing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_send_o |-> (armed && gap == DELAY));

  assert_fb_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_send_o && since_rst >= 4) |-> tx_data_o[7] == $past(fb_i, 3));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(out_o));
endmodule

bind slv_bus_responder slv_bus_responder_chk #(
  .NODE_ADDR(NODE_ADDR), .BIT_CYCLES(BIT_CYCLES), .GAP_BITS(GAP_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
  .fb_i(fb_i), .tx_send_o(tx_send_o), .tx_data_o(tx_data_o), .out_o(out_o)
);

// File: tb/slv_bus_responder_tb.sv
module slv_bus_responder_tb;
  localparam logic [2:0] ADDR = 3'd5;
  localparam int BC = 4;
  localparam int GB = 2;
  localparam int D  = BC * GB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       fb = 1'b0;
  logic       tx_send;
  logic [7:0] tx_data;
  logic       out;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int n_send = 0;
  bit done = 0;
  int         exp_cyc[$];
  logic [7:0] exp_dat[$];
  logic       prev_send = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slv_bus_responder #(.NODE_ADDR(ADDR), .BIT_CYCLES(BC), .GAP_BITS(GB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .fb_i(fb), .tx_send_o(tx_send), .tx_data_o(tx_data), .out_o(out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every reply pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_send && prev_send) chk(0, "R6 pulse width", 2, 1);
      if (tx_send) begin
        n_send++;
        if (exp_dat.size() == 0) chk(0, "R4/R8/R9 unexpected reply", tx_data, 0);
        else begin
          automatic int         ec = exp_cyc.pop_front();
          automatic logic [7:0] ed = exp_dat.pop_front();
          chk(tx_data == ed, "R5/R7 reply byte", tx_data, ed);
          chk(cyc == ec, "R6 reply cycle", cyc, ec);
        end
      end
      prev_send <= tx_send;
    end
  end

  task automatic put_byte(input logic [7:0] b, output int acc);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    acc = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: a matching poll pushes its expected reply
  task automatic poll(input logic [7:0] b, input logic fbv);
    int acc;
    fb = fbv;
    idle(4);
    put_byte(b, acc);
    chk(out == b[7], "R3 out after poll", out, b[7]);
    exp_cyc.push_back(acc + D);
    exp_dat.push_back({fbv, 4'h0, ADDR});
    idle(D + 4);
  endtask

  initial begin
    int acc, base;
    idle(3);
    chk(out == 1'b0, "R1 out in reset", out, 0);
    chk(tx_send == 1'b0, "R1 send in reset", tx_send, 0);
    chk(tx_data == 8'h00, "R1 data in reset", tx_data, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    poll(8'h85, 1'b1);                      // R3 R5 R6 R7
    poll(8'h05, 1'b0);
    poll(8'hFD, 1'b0);                      // R2: bits 6:3 set, still matches
    poll(8'h7D, 1'b1);                      // R2: out goes low

    // R4: mismatch leaves out and stays silent
    base = n_send;
    put_byte(8'h83, acc);
    chk(out == 1'b0, "R4 out on mismatch", out, 0);
    idle(D + 5);
    chk(n_send == base, "R4 no reply on mismatch", n_send, base);

    // R10: hold across idle time and foreign traffic
    poll(8'h85, 1'b0);
    idle(50);
    chk(out == 1'b1, "R10 out held idle", out, 1);
    put_byte(8'h02, acc);
    idle(2);
    chk(out == 1'b1, "R10 out held after foreign byte", out, 1);

    // R8: feedback toggling alone never sends
    base = n_send;
    for (int i = 0; i < 20; i++) begin
      fb = ~fb;
      idle(3);
    end
    idle(D + 4);
    chk(n_send == base, "R8 no reply on feedback change", n_send, base);

    // R9: cancel by a foreign byte
    base = n_send;
    put_byte(8'h05, acc);
    idle(2);
    put_byte(8'h81, acc);
    idle(D + 5);
    chk(n_send == base, "R9 cancelled reply", n_send, base);
    chk(out == 1'b0, "R9 out from first poll", out, 0);

    // R9: restart by a second matching byte
    fb = 1'b1;
    idle(4);
    base = n_send;
    put_byte(8'h85, acc);
    idle(2);
    put_byte(8'h05, acc);
    exp_cyc.push_back(acc + D);
    exp_dat.push_back({1'b1, 4'h0, ADDR});
    idle(D + 5);
    chk(n_send == base + 1, "R9 single reply after restart", n_send, base + 1);
    chk(out == 1'b0, "R9 out from second poll", out, 0);

    // R7: reply reports the level at send time, not at poll time
    fb = 1'b0;
    idle(4);
    put_byte(8'h05, acc);
    fb = 1'b1;
    exp_cyc.push_back(acc + D);
    exp_dat.push_back({1'b1, 4'h0, ADDR});
    idle(D + 5);

    chk(exp_dat.size() == 0, "R6 all replies seen", exp_dat.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule